// File: doc/BRIEF.md
# Dual-Host Bank-Swap Mailbox Controller

This block joins a host 8-bit CPU bus and a coprocessor CPU bus. Two 32 KB shared RAM banks sit behind it. Each side always sees a different bank, and a single swap bit exchanges them. Each side has one control register. The host register opens cartridge-style windows onto its bank, picks the 16 KB half that those windows show, swaps the banks and holds the coprocessor in soft reset. The coprocessor register chooses where its bank window sits in its own 64 KB map and which half that window shows. Every other coprocessor address goes to its private system RAM.

Bit 7 of both registers is one shared semaphore bit. The host clears it to hand a prepared bank to the coprocessor. The coprocessor sets it when its work is finished. During boot, the host loads code into its bank with the coprocessor held in reset. It then swaps the banks, clears the semaphore, releases the reset and polls for the semaphore to return to 1.

Top module: `xbank_mailbox`

## Requirements
- R1: After reset the host register reads 0xCC and the coprocessor register reads 0xBF, `cop_rst` is 1, and both host window enables are 0.
- R2: A host write with bit 7 = 0 clears the semaphore, and a coprocessor register write with bit 7 = 1 sets it. Writes with the other bit-7 value leave it unchanged. Both registers return the semaphore in bit 7.
- R3: If the host clears the semaphore and the coprocessor sets it in the same cycle, the semaphore ends at 1.
- R4: Host bit 1 is the swap bit. `h_bank_id` equals it and `c_bank_id` is its inverse, so the two sides never see the same bank.
- R5: Host bit 0 is the run bit, and `cop_rst` equals its inverse. While the run bit is 0, the coprocessor register returns to window 0 and half 1, and coprocessor writes are ignored, including writes to the semaphore.
- R6: Host bit 4 maps the bank into host 0x8000–0x9FFF and host bit 5 maps it into 0xA000–0xBFFF. `h_bank_act` is high only for a requested host address inside an enabled window, and `h_win_lo_en` and `h_win_hi_en` show the two bits.
- R7: Host bit 3 selects the bank half, and `h_bank_addr` = {bit 3, h_addr[13:0]}.
- R8: When coprocessor bit 6 is 0, the bank occupies 0xC000–0xFFFF. When it is 1, the bank occupies 0x4000–0x7FFF. `c_sysram_sel` is high for every requested address that is neither the bank window nor the register.
- R9: Coprocessor bit 5 selects the bank half, and `c_bank_addr` = {bit 5, c_addr[13:0]}.
- R10: A register read returns data on `h_rdata` or `c_rdata` one cycle after the request. Unused bits read as 1: host bits 6 and 2, and coprocessor bits 4 to 0.
- R11: The coprocessor register answers at every address from 0x0200 to 0x020F, and 0x0210 is system RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host bus cycle valid |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 16 | Host address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host register read data, valid one cycle after the read |
| h_bank_act | output | 1 | Host access targets its bank |
| h_bank_id | output | 1 | Bank index the host sees |
| h_bank_addr | output | 15 | Address into the host's bank |
| h_win_lo_en | output | 1 | Bank mapped at host 0x8000–0x9FFF |
| h_win_hi_en | output | 1 | Bank mapped at host 0xA000–0xBFFF |
| c_req | input | 1 | Coprocessor bus cycle valid |
| c_we | input | 1 | Coprocessor write strobe |
| c_addr | input | 16 | Coprocessor address |
| c_wdata | input | 8 | Coprocessor write data |
| c_rdata | output | 8 | Coprocessor register read data, valid one cycle after the read |
| c_bank_act | output | 1 | Coprocessor access targets its bank |
| c_bank_id | output | 1 | Bank index the coprocessor sees |
| c_bank_addr | output | 15 | Address into the coprocessor's bank |
| c_sysram_sel | output | 1 | Coprocessor access targets system RAM |
| cop_rst | output | 1 | Coprocessor CPU reset, active high |

## Verification
The bench builds the block with its default parameters. The host register sits at 0xD5C0, the coprocessor register spans 16 addresses from 0x0200, and each bank half covers 14 address bits. With these values the real boundaries can be tested directly: window edges at 0x8000, 0xA000, 0xC000 and 0x4000, the host 0xBFFC and coprocessor 0xFFFC aliasing to the same bank word, and the first address past the register mirror at 0x0210. A table walks through combinations of window, half and window-position settings. Directed sequences then cover the semaphore race, the writes that are ignored during soft reset, and the return of the coprocessor fields to their defaults.

// File: rtl/xbm_pkg.sv
package xbm_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // host register bit positions
    localparam int H_SEM   = 7;
    localparam int H_MAPHI = 5;
    localparam int H_MAPLO = 4;
    localparam int H_HALF  = 3;
    localparam int H_SWAP  = 1;
    localparam int H_RUN   = 0;

    // coprocessor register bit positions
    localparam int C_SEM  = 7;
    localparam int C_WIN  = 6;
    localparam int C_HALF = 5;

    // 8 KB host window segments (address bits 15:13)
    localparam logic [2:0] HOST_SEG_LO = 3'd4;
    localparam logic [2:0] HOST_SEG_HI = 3'd5;
    // 16 KB coprocessor bank zones (address bits 15:14)
    localparam logic [1:0] COP_ZONE_LOW  = 2'd1;
    localparam logic [1:0] COP_ZONE_HIGH = 2'd3;

    typedef struct packed {
        logic map_hi;
        logic map_lo;
        logic half;
        logic swap;
        logic run;
    } host_ctl_t;

    typedef struct packed {
        logic win_low;
        logic half;
    } cop_ctl_t;

    localparam host_ctl_t HOST_CTL_RST = '{map_hi: 1'b0, map_lo: 1'b0, half: 1'b1,
                                           swap: 1'b0, run: 1'b0};
    localparam cop_ctl_t  COP_CTL_RST  = '{win_low: 1'b0, half: 1'b1};

    function automatic host_ctl_t host_unpack(logic [DATA_W-1:0] b);
        host_ctl_t c;
        c.map_hi = b[H_MAPHI];
        c.map_lo = b[H_MAPLO];
        c.half   = b[H_HALF];
        c.swap   = b[H_SWAP];
        c.run    = b[H_RUN];
        return c;
    endfunction

    function automatic cop_ctl_t cop_unpack(logic [DATA_W-1:0] b);
        cop_ctl_t c;
        c.win_low = b[C_WIN];
        c.half    = b[C_HALF];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] host_pack(logic sem, host_ctl_t c);
        return {sem, 1'b1, c.map_hi, c.map_lo, c.half, 1'b1, c.swap, c.run};
    endfunction

    function automatic logic [DATA_W-1:0] cop_pack(logic sem, cop_ctl_t c);
        return {sem, c.win_low, c.half, 5'b11111};
    endfunction

endpackage

// File: rtl/xbm_sem.sv
module xbm_sem (
    input  logic clk,
    input  logic rst,
    input  logic host_clr,
    input  logic cop_set,
    output logic sem
);
    always_ff @(posedge clk) begin
        if (rst)           sem <= 1'b1;
        else if (cop_set)  sem <= 1'b1;
        else if (host_clr) sem <= 1'b0;
    end

    p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
        cop_set |=> sem);
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (host_clr && !cop_set) |=> !sem);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!host_clr && !cop_set) |=> $stable(sem));
endmodule

// File: rtl/xbm_host_regs.sv
module xbm_host_regs
    import xbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  host_ctl_t         wr_val,
    output host_ctl_t         ctl
);
    always_ff @(posedge clk) begin
        if (rst)        ctl <= HOST_CTL_RST;
        else if (wr_en) ctl <= wr_val;
    end

    p_run_load_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctl.run == $past(wr_val.run)));
    p_swap_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctl.swap));
endmodule

// File: rtl/xbm_cop_regs.sv
module xbm_cop_regs
    import xbm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      wr_en,
    input  cop_ctl_t  wr_val,
    output cop_ctl_t  ctl
);
    always_ff @(posedge clk) begin
        if (rst || !run) ctl <= COP_CTL_RST;
        else if (wr_en)  ctl <= wr_val;
    end

    p_forced_default_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> (ctl == COP_CTL_RST));
    p_half_load_r9: assert property (@(posedge clk) disable iff (rst)
        (run && wr_en) |=> (ctl.half == $past(wr_val.half)));
endmodule

// File: rtl/xbank_mailbox.sv
module xbank_mailbox
    import xbm_pkg::*;
#(
    parameter logic [15:0] HOST_REG_ADDR = 16'hD5C0,
    parameter logic [15:0] COP_REG_BASE  = 16'h0200,
    parameter int          COP_SPAN_LOG2 = 4,
    parameter int          HALF_AW       = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                h_req,
    input  logic                h_we,
    input  logic [ADDR_W-1:0]   h_addr,
    input  logic [DATA_W-1:0]   h_wdata,
    output logic [DATA_W-1:0]   h_rdata,
    output logic                h_bank_act,
    output logic                h_bank_id,
    output logic [HALF_AW:0]    h_bank_addr,
    output logic                h_win_lo_en,
    output logic                h_win_hi_en,
    input  logic                c_req,
    input  logic                c_we,
    input  logic [ADDR_W-1:0]   c_addr,
    input  logic [DATA_W-1:0]   c_wdata,
    output logic [DATA_W-1:0]   c_rdata,
    output logic                c_bank_act,
    output logic                c_bank_id,
    output logic [HALF_AW:0]    c_bank_addr,
    output logic                c_sysram_sel,
    output logic                cop_rst
);
    localparam int REG_TAG_W = ADDR_W - COP_SPAN_LOG2;

    host_ctl_t hctl;
    cop_ctl_t  cctl;
    logic      sem;

    logic h_reg_hit, c_reg_hit;
    logic h_wr, c_wr, h_rd, c_rd;
    logic h_in_lo, h_in_hi, c_in_zone;

    // address decode
    always_comb begin
        h_reg_hit = (h_addr == HOST_REG_ADDR);
        c_reg_hit = (c_addr[ADDR_W-1:COP_SPAN_LOG2] == COP_REG_BASE[ADDR_W-1:COP_SPAN_LOG2]);
        h_wr = h_req && h_we && h_reg_hit;
        h_rd = h_req && !h_we && h_reg_hit;
        c_wr = c_req && c_we && c_reg_hit && hctl.run;
        c_rd = c_req && !c_we && c_reg_hit;

        h_in_lo = (h_addr[ADDR_W-1:ADDR_W-3] == HOST_SEG_LO) && hctl.map_lo;
        h_in_hi = (h_addr[ADDR_W-1:ADDR_W-3] == HOST_SEG_HI) && hctl.map_hi;
        c_in_zone = (c_addr[ADDR_W-1:ADDR_W-2] ==
                     (cctl.win_low ? COP_ZONE_LOW : COP_ZONE_HIGH));
    end

    xbm_host_regs u_hregs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (h_wr),
        .wr_val (host_unpack(h_wdata)),
        .ctl    (hctl)
    );

    xbm_cop_regs u_cregs (
        .clk    (clk),
        .rst    (rst),
        .run    (hctl.run),
        .wr_en  (c_wr),
        .wr_val (cop_unpack(c_wdata)),
        .ctl    (cctl)
    );

    xbm_sem u_sem (
        .clk      (clk),
        .rst      (rst),
        .host_clr (h_wr && !h_wdata[H_SEM]),
        .cop_set  (c_wr && c_wdata[C_SEM]),
        .sem      (sem)
    );

    // registered read ports
    always_ff @(posedge clk) begin
        if (rst) begin
            h_rdata <= '0;
            c_rdata <= '0;
        end else begin
            if (h_rd) h_rdata <= host_pack(sem, hctl);
            if (c_rd) c_rdata <= cop_pack(sem, cctl);
        end
    end

    // bank and window outputs
    always_comb begin
        h_bank_act   = h_req && (h_in_lo || h_in_hi);
        h_bank_id    = hctl.swap;
        h_bank_addr  = {hctl.half, h_addr[HALF_AW-1:0]};
        h_win_lo_en  = hctl.map_lo;
        h_win_hi_en  = hctl.map_hi;
        c_bank_act   = c_req && c_in_zone;
        c_bank_id    = !hctl.swap;
        c_bank_addr  = {cctl.half, c_addr[HALF_AW-1:0]};
        c_sysram_sel = c_req && !c_in_zone && !c_reg_hit;
        cop_rst      = !hctl.run;
    end

    p_banks_differ_r4: assert property (@(posedge clk) disable iff (rst)
        h_bank_id != c_bank_id);
    p_sys_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(c_bank_act && c_sysram_sel));
    p_host_ones_r10: assert property (@(posedge clk) disable iff (rst)
        h_rd |=> (h_rdata[6] && h_rdata[2]));
    p_cop_ones_r10: assert property (@(posedge clk) disable iff (rst)
        c_rd |=> (c_rdata[4:0] == 5'b11111));
    p_sem_same_r2: assert property (@(posedge clk) disable iff (rst)
        (h_rd && c_rd) |=> (h_rdata[7] == c_rdata[7]));
    p_reg_not_bank_r11: assert property (@(posedge clk) disable iff (rst)
        (c_req && c_reg_hit) |-> (!c_sysram_sel && !c_bank_act));

    logic [REG_TAG_W-1:0] unused_tag;
    assign unused_tag = COP_REG_BASE[ADDR_W-1:COP_SPAN_LOG2];
endmodule

// File: tb/sim_xbank_mailbox.sv
module sim_xbank_mailbox;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_req = 0, h_we = 0;
    logic [15:0] h_addr = '0;
    logic [7:0]  h_wdata = '0;
    logic [7:0]  h_rdata;
    logic        h_bank_act, h_bank_id, h_win_lo_en, h_win_hi_en;
    logic [14:0] h_bank_addr;
    logic        c_req = 0, c_we = 0;
    logic [15:0] c_addr = '0;
    logic [7:0]  c_wdata = '0;
    logic [7:0]  c_rdata;
    logic        c_bank_act, c_bank_id, c_sysram_sel, cop_rst;
    logic [14:0] c_bank_addr;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    xbank_mailbox u0 (
        .clk(clk), .rst(rst),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_bank_act(h_bank_act), .h_bank_id(h_bank_id),
        .h_bank_addr(h_bank_addr), .h_win_lo_en(h_win_lo_en), .h_win_hi_en(h_win_hi_en),
        .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
        .c_rdata(c_rdata), .c_bank_act(c_bank_act), .c_bank_id(c_bank_id),
        .c_bank_addr(c_bank_addr), .c_sysram_sel(c_sysram_sel), .cop_rst(cop_rst)
    );

    // vector: hreg[48:41] creg[40:33] side[32] addr[31:16] act[15] baddr[14:0]
    localparam int NV = 12;
    localparam logic [48:0] VECS [0:NV-1] = '{
        {8'h31, 8'h00, 1'b0, 16'h8123, 1'b1, 15'h0123},
        {8'h31, 8'h00, 1'b0, 16'hA456, 1'b1, 15'h2456},
        {8'h29, 8'h00, 1'b0, 16'h8123, 1'b0, 15'h4123},
        {8'h29, 8'h00, 1'b0, 16'hBFFC, 1'b1, 15'h7FFC},
        {8'h39, 8'h00, 1'b0, 16'hC000, 1'b0, 15'h4000},
        {8'h01, 8'h00, 1'b0, 16'hA000, 1'b0, 15'h2000},
        {8'h01, 8'h20, 1'b1, 16'hFFFC, 1'b1, 15'h7FFC},
        {8'h01, 8'h20, 1'b1, 16'h4010, 1'b0, 15'h4010},
        {8'h01, 8'h40, 1'b1, 16'h4010, 1'b1, 15'h0010},
        {8'h01, 8'h40, 1'b1, 16'hC001, 1'b0, 15'h0001},
        {8'h01, 8'h60, 1'b1, 16'h7FFF, 1'b1, 15'h7FFF},
        {8'h01, 8'h00, 1'b1, 16'h0205, 1'b0, 15'h0205}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] d);
        @(negedge clk);
        h_req = 1; h_we = 1; h_addr = 16'hD5C0; h_wdata = d;
        @(negedge clk);
        h_req = 0; h_we = 0;
    endtask

    task automatic host_rd(output logic [7:0] d);
        @(negedge clk);
        h_req = 1; h_we = 0; h_addr = 16'hD5C0;
        @(negedge clk);
        h_req = 0;
        d = h_rdata;
    endtask

    task automatic cop_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        c_req = 1; c_we = 1; c_addr = a; c_wdata = d;
        @(negedge clk);
        c_req = 0; c_we = 0;
    endtask

    task automatic cop_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        c_req = 1; c_we = 0; c_addr = a;
        @(negedge clk);
        c_req = 0;
        d = c_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        host_rd(rv); chk("R1 host reset", rv, 8'hCC);
        cop_rd(16'h0200, rv); chk("R1 cop reset", rv, 8'hBF);
        chk("R1 cop_rst", cop_rst, 1);
        chk("R1 windows off", {h_win_hi_en, h_win_lo_en}, 0);
        chk("R4 reset ids", {h_bank_id, c_bank_id}, 2'b01);

        // R5 coprocessor writes ignored while held
        cop_wr(16'h0200, 8'h40);
        cop_rd(16'h0200, rv); chk("R5 cop write ignored", rv, 8'hBF);
        host_wr(8'h4C);
        cop_wr(16'h0200, 8'h80);
        host_rd(rv); chk("R5 sem set ignored in reset", rv, 8'h4C);

        host_wr(8'h01);
        chk("R5 cop_rst released", cop_rst, 0);
        host_rd(rv); chk("R10 unused ones", rv, 8'h45);

        // R2 semaphore
        cop_wr(16'h0200, 8'h80);
        host_rd(rv); chk("R2 cop sets sem", rv, 8'hC5);
        cop_rd(16'h020F, rv); chk("R11 mirror read", rv, 8'h9F);
        host_wr(8'h81);
        host_rd(rv); chk("R2 host bit7=1 ignored", rv, 8'hC5);
        host_wr(8'h01);
        cop_wr(16'h0200, 8'h00);
        host_rd(rv); chk("R2 cop bit7=0 ignored", rv, 8'h45);

        // R3 same-cycle race
        cop_wr(16'h0200, 8'h80);
        @(negedge clk);
        h_req = 1; h_we = 1; h_addr = 16'hD5C0; h_wdata = 8'h01;
        c_req = 1; c_we = 1; c_addr = 16'h0200; c_wdata = 8'h80;
        @(negedge clk);
        h_req = 0; h_we = 0; c_req = 0; c_we = 0;
        host_rd(rv); chk("R3 cop wins race", rv, 8'hC5);

        // R4 swap
        host_wr(8'h03);
        chk("R4 swapped ids", {h_bank_id, c_bank_id}, 2'b10);

        // R6 window enables
        host_wr(8'h21);
        chk("R6 enables", {h_win_hi_en, h_win_lo_en}, 2'b10);

        // R5 defaults restored by soft reset
        cop_wr(16'h0200, 8'hC0);
        cop_rd(16'h0200, rv); chk("R8 cop reg loaded", rv, 8'hDF);
        host_wr(8'h00);
        chk("R5 cop_rst asserted", cop_rst, 1);
        @(negedge clk);
        cop_rd(16'h0200, rv); chk("R5 defaults forced", rv & 8'h7F, 8'h3F);
        host_wr(8'h01);
        cop_rd(16'h0200, rv); chk("R5 defaults persist", rv & 8'h7F, 8'h3F);

        // R11 register span edge
        @(negedge clk);
        c_req = 1; c_addr = 16'h0210; #1;
        chk("R11 past span is sysram", {c_sysram_sel, c_bank_act}, 2'b10);
        c_addr = 16'h020A; #1;
        chk("R11 inside span", {c_sysram_sel, c_bank_act}, 2'b00);
        c_req = 0;

        // R6 R7 R8 R9 decode table
        for (int i = 0; i < NV; i++) begin
            logic [48:0] v;
            logic        exp_sys;
            v = VECS[i];
            host_wr(v[48:41]);
            if (v[32]) cop_wr(16'h0200, v[40:33]);
            @(negedge clk);
            if (v[32]) begin
                c_req = 1; c_addr = v[31:16]; #1;
                exp_sys = !v[15] && (v[31:20] != 12'h020);
                chk("R8 cop bank act", c_bank_act, v[15]);
                chk("R9 cop bank addr", c_bank_addr, v[14:0]);
                chk("R8 cop sysram", c_sysram_sel, exp_sys);
                c_req = 0;
            end else begin
                h_req = 1; h_addr = v[31:16]; #1;
                chk("R6 host bank act", h_bank_act, v[15]);
                chk("R7 host bank addr", h_bank_addr, v[14:0]);
                h_req = 0;
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule